// File: doc/BRIEF.md
# Run-Time Configurable STM-N Byte Interleaver

This block joins up to sixteen STM-1-rate byte tributaries into one aggregate STM-N byte stream for transmission, and splits a received aggregate byte stream back into per-tributary bytes. A mode input selects the multiplicity N, which is 1, 2, 4, 8 or 16. The same datapath serves every N; only the set of active tributaries and the length of the interleave cycle change. An STM-1 frame is 9 rows of 270 byte columns (9 overhead plus 261 payload) and repeats at 8 kHz at every level, so an STM-N frame carries N times as many bytes in the same period. Byte interleaving keeps that frame period.

On the transmit side, each tributary writes a one-byte holding stage through its own enable and may mark the byte as a frame start. The aggregate side emits one byte every clock. It reads the holding stages in ascending tributary order, one byte per tributary, and the cycle repeats every N clocks. On the receive side, a phase counter is restarted by the aggregate frame-start flag and steers each incoming byte to one tributary output, with a one-cycle valid pulse. A new mode is adopted only at a frame boundary, so a mode change can never cut an interleave cycle short.

Top module: `stmn_byte_interleaver`

## Requirements
- R1: The 3-bit `mode_sel` code c selects N = 2^c for c = 0..4 (1, 2, 4, 8, 16). Codes 5, 6 and 7 act as code 4 (N = 16). The active tributaries are 0 to N-1.
- R2: Transmit byte order. Each clock, one interleave phase p is served, with p running 0, 1, ..., N-1 and then wrapping. One clock after phase p is served, `tx_agg_data` holds the byte that tributary p last wrote through `tx_trib_en[p]` at an earlier edge. A write on the same edge is not yet seen.
- R3: Transmit frame start. A write with `tx_trib_fs[i]` high sets a pending marker for tributary i. A write with the marker low clears it. An aggregate frame start happens at a phase-0 clock where every tributary active under the current `mode_sel` has its marker pending. One clock later `tx_agg_fs` is high together with tributary 0's byte, and the markers are cleared unless they are rewritten at that edge. A phase-0 clock with a missing marker produces no frame start.
- R4: The transmit side adopts a new `mode_sel` only at a transmit frame start. Between frame starts the interleave cycle keeps its length whatever `mode_sel` does. After reset the cycle length is 1.
- R5: Receive steering. A byte taken with `rx_agg_fs` high goes to tributary 0. The k-th byte after it goes to tributary k mod N. Before the first frame start every byte goes to tributary 0.
- R6: Receive timing. One clock after a byte is taken, the selected tributary's `rx_trib_valid` bit is high for exactly one cycle, and its slice of `rx_trib_data` holds the byte. At most one valid bit is high at a time. A slice that is not selected keeps its value.
- R7: A tributary outside the active set on the receive side has its data slice at zero and its valid bit low.
- R8: The receive side adopts `mode_sel` only on a byte that carries `rx_agg_fs`, and that byte already uses the new N. After reset N is 1 there.
- R9: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Aggregate byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Multiplicity code, N = 2^code, saturating at 16 |
| tx_trib_data | input | 128 | Tributary bytes; tributary i on bits 8i+7:8i |
| tx_trib_en | input | 16 | Per-tributary write enable into the holding stage |
| tx_trib_fs | input | 16 | Per-tributary frame-start marker, taken with the write |
| tx_agg_data | output | 8 | Interleaved aggregate byte |
| tx_agg_fs | output | 1 | Aggregate frame start, on tributary 0's byte |
| rx_agg_data | input | 8 | Received aggregate byte, one per clock |
| rx_agg_fs | input | 1 | Marks the received byte that belongs to tributary 0 at frame start |
| rx_trib_data | output | 128 | Split-out bytes; tributary i on bits 8i+7:8i |
| rx_trib_valid | output | 16 | One-cycle strobe per tributary for a new byte |

## Verification
The hardest case to reach is a frame start on the transmit side. It needs every active tributary's marker to still be pending at a phase-0 clock, and any later write without the marker wipes that out. The stimulus therefore injects a marker write on all tributaries and then keeps the enables quiet for a full 16-clock window. Some injections leave out one active tributary, to show that an incomplete set is not taken as a frame start. The mode code is changed between frame starts and also at random while no frame start is due, including the saturating codes 5 to 7, so the cycle length must survive a mode change that is not yet allowed to take effect.

// File: rtl/stmn_pkg.sv
package stmn_pkg;

   // Mode code to log2 of the multiplicity, saturating at the largest supported value.
   function automatic int unsigned mode_to_log(input int unsigned code, input int unsigned max_log);
      return (code > max_log) ? max_log : code;
   endfunction

   // Number of active tributaries for a given log2 multiplicity.
   function automatic int unsigned log_to_count(input int unsigned log_n);
      return 32'd1 << log_n;
   endfunction

   // Wrap mask of the interleave phase for a given log2 multiplicity.
   function automatic int unsigned log_to_mask(input int unsigned log_n);
      return (32'd1 << log_n) - 32'd1;
   endfunction

endpackage

// File: rtl/stmn_phase_ctr.sv
// Interleave phase counter whose modulus (a power of two) is reloaded only on restart.
module stmn_phase_ctr
   import stmn_pkg::*;
#(
   parameter int unsigned PH_W  = 4,
   parameter int unsigned LOG_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [LOG_W-1:0] log_new,
   output logic [PH_W-1:0]  phase_q,
   output logic [PH_W-1:0]  phase_now,
   output logic [LOG_W-1:0] log_now
);

   logic [LOG_W-1:0] log_q;
   logic [PH_W-1:0]  wrap_mask;
   logic [PH_W-1:0]  phase_next;

   always_comb begin
      log_now    = restart ? log_new : log_q;
      phase_now  = restart ? '0 : phase_q;
      wrap_mask  = PH_W'(log_to_mask(32'(log_now)));
      phase_next = (phase_now + PH_W'(1)) & wrap_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         log_q   <= '0;
         phase_q <= '0;
      end else begin
         log_q   <= log_now;
         phase_q <= phase_next;
      end
   end

endmodule

// File: rtl/stmn_tx_interleave.sv
// Transmit side: per-tributary holding stages read out in ascending phase order.
module stmn_tx_interleave
   import stmn_pkg::*;
#(
   parameter int unsigned NUM_TRIB  = 16,
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned PH_W      = 4,
   parameter int unsigned LOG_W     = 3,
   parameter int unsigned MUX_STYLE = 0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [LOG_W-1:0]           log_sel,
   input  logic [NUM_TRIB*BYTE_W-1:0] trib_data,
   input  logic [NUM_TRIB-1:0]        trib_en,
   input  logic [NUM_TRIB-1:0]        trib_fs,
   output logic [BYTE_W-1:0]          agg_data,
   output logic                       agg_fs
);

   logic [NUM_TRIB-1:0][BYTE_W-1:0] hold_q;
   logic [NUM_TRIB-1:0]             pend_q;
   logic [NUM_TRIB-1:0]             need_mask;
   logic [NUM_TRIB-1:0]             marks_ok;
   logic                            frame_go;
   logic [PH_W-1:0]                 phase_q;
   logic [PH_W-1:0]                 phase_now;
   logic [LOG_W-1:0]                log_now;
   logic [BYTE_W-1:0]               pick_byte;

   // Tributaries that must carry a marker under the mode presented now.
   always_comb begin
      for (int i = 0; i < NUM_TRIB; i++) begin
         need_mask[i] = (32'(i) < log_to_count(32'(log_sel)));
      end
      marks_ok = pend_q | ~need_mask;
      frame_go = (phase_q == '0) && (&marks_ok);
   end

   stmn_phase_ctr #(
      .PH_W  (PH_W),
      .LOG_W (LOG_W)
   ) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (frame_go),
      .log_new   (log_sel),
      .phase_q   (phase_q),
      .phase_now (phase_now),
      .log_now   (log_now)
   );

   generate
      if (MUX_STYLE == 0) begin : g_index_mux
         assign pick_byte = hold_q[phase_now];
      end else begin : g_andor_mux
         always_comb begin
            pick_byte = '0;
            for (int i = 0; i < NUM_TRIB; i++) begin
               pick_byte = pick_byte | (hold_q[i] & {BYTE_W{phase_now == PH_W'(i)}});
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q   <= '0;
         pend_q   <= '0;
         agg_data <= '0;
         agg_fs   <= 1'b0;
      end else begin
         agg_data <= pick_byte;
         agg_fs   <= frame_go;
         for (int i = 0; i < NUM_TRIB; i++) begin
            if (trib_en[i]) begin
               hold_q[i] <= trib_data[i*BYTE_W +: BYTE_W];
               pend_q[i] <= trib_fs[i];
            end else if (frame_go) begin
               pend_q[i] <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/stmn_rx_deinterleave.sv
// Receive side: steers each aggregate byte to one tributary with a valid pulse.
module stmn_rx_deinterleave
   import stmn_pkg::*;
#(
   parameter int unsigned NUM_TRIB = 16,
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned PH_W     = 4,
   parameter int unsigned LOG_W    = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [LOG_W-1:0]           log_sel,
   input  logic [BYTE_W-1:0]          agg_data,
   input  logic                       agg_fs,
   output logic [NUM_TRIB*BYTE_W-1:0] trib_data,
   output logic [NUM_TRIB-1:0]        trib_valid
);

   logic [PH_W-1:0]     phase_q;
   logic [PH_W-1:0]     dest;
   logic [LOG_W-1:0]    log_now;
   logic [NUM_TRIB-1:0] live_mask;
   logic [NUM_TRIB-1:0] hit;

   stmn_phase_ctr #(
      .PH_W  (PH_W),
      .LOG_W (LOG_W)
   ) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (agg_fs),
      .log_new   (log_sel),
      .phase_q   (phase_q),
      .phase_now (dest),
      .log_now   (log_now)
   );

   always_comb begin
      for (int t = 0; t < NUM_TRIB; t++) begin
         live_mask[t] = (32'(t) < log_to_count(32'(log_now)));
         hit[t]       = live_mask[t] && (dest == PH_W'(t));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trib_data  <= '0;
         trib_valid <= '0;
      end else begin
         for (int t = 0; t < NUM_TRIB; t++) begin
            trib_valid[t] <= hit[t];
            if (!live_mask[t]) begin
               trib_data[t*BYTE_W +: BYTE_W] <= '0;
            end else if (hit[t]) begin
               trib_data[t*BYTE_W +: BYTE_W] <= agg_data;
            end
         end
      end
   end

endmodule

// File: rtl/stmn_byte_interleaver.sv
// Top: shared mode decode feeding the transmit interleaver and receive splitter.
module stmn_byte_interleaver
   import stmn_pkg::*;
#(
   parameter int unsigned NUM_TRIB  = 16,
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned MUX_STYLE = 0,
   localparam int unsigned LOG_TRIB = $clog2(NUM_TRIB),
   localparam int unsigned MODE_W   = $clog2(LOG_TRIB + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [MODE_W-1:0]          mode_sel,
   input  logic [NUM_TRIB*BYTE_W-1:0] tx_trib_data,
   input  logic [NUM_TRIB-1:0]        tx_trib_en,
   input  logic [NUM_TRIB-1:0]        tx_trib_fs,
   output logic [BYTE_W-1:0]          tx_agg_data,
   output logic                       tx_agg_fs,
   input  logic [BYTE_W-1:0]          rx_agg_data,
   input  logic                       rx_agg_fs,
   output logic [NUM_TRIB*BYTE_W-1:0] rx_trib_data,
   output logic [NUM_TRIB-1:0]        rx_trib_valid
);

   generate
      if (NUM_TRIB < 2 || (32'd1 << LOG_TRIB) != NUM_TRIB) begin : g_bad_count
         $error("NUM_TRIB must be a power of two of at least 2");
      end
      if (BYTE_W < 1) begin : g_bad_width
         $error("BYTE_W must be at least 1");
      end
      if (MUX_STYLE > 1) begin : g_bad_style
         $error("MUX_STYLE must be 0 or 1");
      end
   endgenerate

   logic [MODE_W-1:0] log_sel;

   assign log_sel = MODE_W'(mode_to_log(32'(mode_sel), LOG_TRIB));

   stmn_tx_interleave #(
      .NUM_TRIB  (NUM_TRIB),
      .BYTE_W    (BYTE_W),
      .PH_W      (LOG_TRIB),
      .LOG_W     (MODE_W),
      .MUX_STYLE (MUX_STYLE)
   ) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .log_sel   (log_sel),
      .trib_data (tx_trib_data),
      .trib_en   (tx_trib_en),
      .trib_fs   (tx_trib_fs),
      .agg_data  (tx_agg_data),
      .agg_fs    (tx_agg_fs)
   );

   stmn_rx_deinterleave #(
      .NUM_TRIB (NUM_TRIB),
      .BYTE_W   (BYTE_W),
      .PH_W     (LOG_TRIB),
      .LOG_W    (MODE_W)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .log_sel    (log_sel),
      .agg_data   (rx_agg_data),
      .agg_fs     (rx_agg_fs),
      .trib_data  (rx_trib_data),
      .trib_valid (rx_trib_valid)
   );

endmodule

// File: rtl/stmn_byte_interleaver_chk.sv
module stmn_byte_interleaver_chk #(
   parameter int unsigned NUM_TRIB = 16,
   parameter int unsigned BYTE_W   = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NUM_TRIB-1:0]        tx_trib_en,
   input logic [NUM_TRIB-1:0]        tx_trib_fs,
   input logic                       tx_agg_fs,
   input logic                       rx_agg_fs,
   input logic [NUM_TRIB*BYTE_W-1:0] rx_trib_data,
   input logic [NUM_TRIB-1:0]        rx_trib_valid
);

   // Set by a marker write on tributary 0, cleared once a frame start is emitted.
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (tx_trib_en[0] && tx_trib_fs[0]) begin
         armed_q <= 1'b1;
      end else if (tx_agg_fs) begin
         armed_q <= 1'b0;
      end
   end

   // R3
   tx_fs_needs_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_agg_fs |-> armed_q);

   // R5
   rx_fs_lands_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_agg_fs |=> rx_trib_valid[0]);

   // R6
   rx_single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rx_trib_valid));

   generate
      for (genvar t = 0; t < NUM_TRIB; t++) begin : g_slice
         // R6 R7
         rx_slice_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rx_trib_valid[t] |->
               ($stable(rx_trib_data[t*BYTE_W +: BYTE_W]) ||
                rx_trib_data[t*BYTE_W +: BYTE_W] == '0));
      end
   endgenerate

endmodule

bind stmn_byte_interleaver stmn_byte_interleaver_chk #(
   .NUM_TRIB (NUM_TRIB),
   .BYTE_W   (BYTE_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tx_trib_en    (tx_trib_en),
   .tx_trib_fs    (tx_trib_fs),
   .tx_agg_fs     (tx_agg_fs),
   .rx_agg_fs     (rx_agg_fs),
   .rx_trib_data  (rx_trib_data),
   .rx_trib_valid (rx_trib_valid)
);

// File: tb/stmn_byte_interleaver_test.sv
module stmn_byte_interleaver_test;

   localparam int NT = 16;
   localparam int BW = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [2:0]      mode_sel = '0;
   logic [NT*BW-1:0] tx_trib_data = '0;
   logic [NT-1:0]   tx_trib_en = '0;
   logic [NT-1:0]   tx_trib_fs = '0;
   logic [BW-1:0]   tx_agg_data;
   logic            tx_agg_fs;
   logic [BW-1:0]   rx_agg_data = '0;
   logic            rx_agg_fs = 1'b0;
   logic [NT*BW-1:0] rx_trib_data;
   logic [NT-1:0]   rx_trib_valid;

   always #4 clk = ~clk;

   stmn_byte_interleaver uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode_sel      (mode_sel),
      .tx_trib_data  (tx_trib_data),
      .tx_trib_en    (tx_trib_en),
      .tx_trib_fs    (tx_trib_fs),
      .tx_agg_data   (tx_agg_data),
      .tx_agg_fs     (tx_agg_fs),
      .rx_agg_data   (rx_agg_data),
      .rx_agg_fs     (rx_agg_fs),
      .rx_trib_data  (rx_trib_data),
      .rx_trib_valid (rx_trib_valid)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // Requirement-level model state.
   logic [BW-1:0] m_hold [NT];
   bit            m_pend [NT];
   int            m_tx_log = 0;
   int            m_tx_ph = 0;
   logic [BW-1:0] e_agg_data = '0;
   logic          e_agg_fs = 1'b0;
   logic [BW-1:0] m_rx_data [NT];
   logic [NT-1:0] e_rx_valid = '0;
   int            m_rx_log = 0;
   int            m_rx_ph = 0;

   function automatic int code_log(input int c);
      return (c > 4) ? 4 : c;   // R1
   endfunction

   task automatic check(input string req, input logic [NT*BW-1:0] act, input logic [NT*BW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_step();
      bit all_marks = 1'b1;
      bit go;
      int nlog;
      int dest;
      int cnt;
      // transmit side
      for (int i = 0; i < (1 << code_log(int'(mode_sel))); i++) begin
         if (!m_pend[i]) all_marks = 1'b0;
      end
      go         = (m_tx_ph == 0) && all_marks;
      nlog       = go ? code_log(int'(mode_sel)) : m_tx_log;
      e_agg_data = m_hold[m_tx_ph];
      e_agg_fs   = go;
      m_tx_ph    = (m_tx_ph + 1) & ((1 << nlog) - 1);
      m_tx_log   = nlog;
      for (int i = 0; i < NT; i++) begin
         if (tx_trib_en[i]) begin
            m_hold[i] = tx_trib_data[i*BW +: BW];
            m_pend[i] = tx_trib_fs[i];
         end else if (go) begin
            m_pend[i] = 1'b0;
         end
      end
      // receive side
      nlog = rx_agg_fs ? code_log(int'(mode_sel)) : m_rx_log;
      dest = rx_agg_fs ? 0 : m_rx_ph;
      cnt  = 1 << nlog;
      for (int t = 0; t < NT; t++) begin
         if (t >= cnt) begin
            m_rx_data[t]  = '0;
            e_rx_valid[t] = 1'b0;
         end else begin
            e_rx_valid[t] = (t == dest);
            if (t == dest) m_rx_data[t] = rx_agg_data;
         end
      end
      m_rx_ph  = (dest + 1) & (cnt - 1);
      m_rx_log = nlog;
   endtask

   task automatic cycle();
      logic [NT*BW-1:0] e_flat;
      @(posedge clk);
      model_step();
      @(negedge clk);
      for (int t = 0; t < NT; t++) e_flat[t*BW +: BW] = m_rx_data[t];
      check("R1 R2 R4 tx byte order", {{(NT*BW-BW){1'b0}}, tx_agg_data}, {{(NT*BW-BW){1'b0}}, e_agg_data});
      check("R3 R4 tx frame start", {{(NT*BW-1){1'b0}}, tx_agg_fs}, {{(NT*BW-1){1'b0}}, e_agg_fs});
      check("R5 R6 R8 rx valid", {{(NT*BW-NT){1'b0}}, rx_trib_valid}, {{(NT*BW-NT){1'b0}}, e_rx_valid});
      check("R6 R7 rx data", rx_trib_data, e_flat);
   endtask

   task automatic drive_random(input bit quiet);
      for (int i = 0; i < NT; i++) begin
         tx_trib_data[i*BW +: BW] = BW'($urandom);
         tx_trib_en[i] = !quiet && (($urandom % 4) == 0);
      end
      tx_trib_fs  = '0;
      rx_agg_data = BW'($urandom);
      rx_agg_fs   = (($urandom % 19) == 0);
   endtask

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < NT; i++) begin
         m_hold[i] = '0;
         m_pend[i] = 1'b0;
         m_rx_data[i] = '0;
      end
      repeat (3) @(negedge clk);
      // R9: reset values
      check("R9 reset tx byte", {{(NT*BW-BW){1'b0}}, tx_agg_data}, '0);
      check("R9 reset tx fs", {{(NT*BW-1){1'b0}}, tx_agg_fs}, '0);
      check("R9 reset rx valid", {{(NT*BW-NT){1'b0}}, rx_trib_valid}, '0);
      check("R9 reset rx data", rx_trib_data, '0);
      rst_n = 1'b1;
      // Before any frame start: N stays 1 on both sides (R4, R8).
      mode_sel = 3'd4;
      for (int c = 0; c < 12; c++) begin
         drive_random(1'b0);
         rx_agg_fs = 1'b0;
         cycle();
      end
      for (int seg = 0; seg < 60; seg++) begin
         mode_sel = 3'($urandom % 8);
         // Marker write on all tributaries; sometimes one active tributary is left out (R3).
         drive_random(1'b0);
         tx_trib_en = '1;
         tx_trib_fs = '1;
         if (($urandom % 4) == 0) begin
            tx_trib_fs[$urandom % (1 << code_log(int'(mode_sel)))] = 1'b0;
         end
         if (seg % 3 == 0) rx_agg_fs = 1'b1;
         cycle();
         // Quiet window so markers survive until a phase-0 clock.
         for (int c = 0; c < 17; c++) begin
            drive_random(1'b1);
            cycle();
         end
         // Free-running traffic with mode changes that must wait for a frame start (R4, R8).
         for (int c = 0; c < 120; c++) begin
            drive_random(1'b0);
            if (($urandom % 29) == 0) mode_sel = 3'($urandom % 8);
            cycle();
         end
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule